// File: doc/BRIEF.md
# Adder Reservation Station Array

This block holds the instructions waiting for one adder unit in a dynamically scheduled pipeline. It has three entries. Each entry has a fixed 4-bit producer tag: 10, 11 and 12 for entries 0, 1 and 2. On issue, the lowest free entry takes an opcode and two source operands. Each operand is either a value that is already known (tag 0) or the tag of the unit that will produce it. The tag of the entry that takes the instruction is returned, so that the renaming logic can mark the destination register as waiting on it.

Every cycle, each entry compares its pending operand tags with the tag on a shared result broadcast bus. On a match it takes the data and clears the tag. When both operand tags of an entry are zero, the entry is ready. If the adder is idle, the lowest-index ready entry goes to it. The adder runs only one operation at a time. An entry stays occupied until its own tag appears on the broadcast bus, which means the unit has written its result. The entry can be reused from the next cycle.

Top module: `rs_array`

## Requirements
- R1: With issue_valid_i high and issue_stall_o low, the lowest-index free entry takes the opcode and both operands at the clock edge. issue_tag_o shows that entry's tag, which is 10 plus the entry index.
- R2: An operand given with tag 0 keeps the data supplied with it. An operand given with a nonzero tag is pending until that tag is broadcast.
- R3: When bcast_valid_i is high and bcast_tag_i equals the nonzero tag of a pending operand, the operand takes bcast_data_i and becomes ready. Broadcasts of any other tag leave it pending.
- R4: If a broadcast and an issue happen in the same cycle, the broadcast is applied to the incoming operands, so an operand tagged with the broadcast tag is stored as ready with the broadcast data.
- R5: issue_stall_o is high exactly when all three entries are occupied. An issue attempted while it is high is ignored.
- R6: An entry is dispatched only when both of its operand tags are 0. When several entries are ready, the lowest index goes first. The dispatch outputs show that entry's opcode, operands and tag.
- R7: An entry is never dispatched in the cycle in which it is issued or in which it captures its last operand. It spends at least one cycle resident first.
- R8: A dispatched entry becomes free in the cycle after its own tag appears on the broadcast bus.
- R9: Only one operation is in flight. After a dispatch, disp_valid_o stays low until the dispatched tag has been broadcast.
- R10: After reset all entries are free, all operand tags are 0, issue_stall_o is low, disp_valid_o is low and issue_tag_o is 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| issue_valid_i | input | 1 | Issue request |
| issue_op_i | input | OP_W | Opcode of the issued instruction |
| issue_a_tag_i | input | 4 | Producer tag of operand A, 0 when data is valid |
| issue_a_data_i | input | DATA_W | Operand A data |
| issue_b_tag_i | input | 4 | Producer tag of operand B, 0 when data is valid |
| issue_b_data_i | input | DATA_W | Operand B data |
| issue_stall_o | output | 1 | No free entry, issue refused |
| issue_tag_o | output | 4 | Tag of the entry the next issue will take |
| bcast_valid_i | input | 1 | Result broadcast valid |
| bcast_tag_i | input | 4 | Tag of the broadcasting producer |
| bcast_data_i | input | DATA_W | Broadcast result value |
| disp_valid_o | output | 1 | Dispatch to the adder this cycle |
| disp_op_o | output | OP_W | Dispatched opcode |
| disp_a_o | output | DATA_W | Dispatched operand A |
| disp_b_o | output | DATA_W | Dispatched operand B |
| disp_tag_o | output | 4 | Tag of the dispatched entry |

## Verification
The assertions assume a well-formed environment, which the stimulus follows throughout:
- The bus never broadcasts tag 0.
- The array's own tags appear on the bus only after the matching dispatch.
- A tag is broadcast at most once while it is outstanding.

Within those limits, the stimulus covers the following cases:
- Full occupancy, including refused issues.
- Captures both at issue and later.
- Chained dependences between entries.
- Broadcasts that match nothing.
- A sweep of every combination of ready and pending operands.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int TagW = 4;
  typedef logic [TagW-1:0] tag_t;
  localparam tag_t TagReady = '0;
endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
  parameter int N     = 3,
  localparam int IdxW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    req_i,
  output logic [N-1:0]    gnt_o,
  output logic [IdxW-1:0] idx_o,
  output logic            any_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
        idx_o    = IdxW'(i);
      end
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pkg::*;
#(
  parameter int   DATA_W = 16,
  parameter int   OP_W   = 3,
  parameter tag_t MY_TAG = tag_t'(10)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [OP_W-1:0]   op_i,
  input  tag_t              a_tag_i,
  input  logic [DATA_W-1:0] a_data_i,
  input  tag_t              b_tag_i,
  input  logic [DATA_W-1:0] b_data_i,
  input  logic              bc_valid_i,
  input  tag_t              bc_tag_i,
  input  logic [DATA_W-1:0] bc_data_i,
  input  logic              disp_i,
  output logic              busy_o,
  output logic              ready_o,
  output logic [OP_W-1:0]   op_o,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o
);
  logic              busy_q, sent_q;
  logic [OP_W-1:0]   op_q;
  tag_t              at_q, bt_q;
  logic [DATA_W-1:0] a_q, b_q;

  // snoop on incoming operands (broadcast wins over issue) and on held ones
  logic a_hit_new, b_hit_new, a_hit_old, b_hit_old, release_hit;
  assign a_hit_new   = bc_valid_i && (a_tag_i != TagReady) && (a_tag_i == bc_tag_i);
  assign b_hit_new   = bc_valid_i && (b_tag_i != TagReady) && (b_tag_i == bc_tag_i);
  assign a_hit_old   = bc_valid_i && (at_q != TagReady) && (at_q == bc_tag_i);
  assign b_hit_old   = bc_valid_i && (bt_q != TagReady) && (bt_q == bc_tag_i);
  assign release_hit = busy_q && sent_q && bc_valid_i && (bc_tag_i == MY_TAG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sent_q <= 1'b0;
      op_q   <= '0;
      at_q   <= TagReady;
      bt_q   <= TagReady;
      a_q    <= '0;
      b_q    <= '0;
    end else if (alloc_i) begin
      busy_q <= 1'b1;
      sent_q <= 1'b0;
      op_q   <= op_i;
      at_q   <= a_hit_new ? TagReady : a_tag_i;
      bt_q   <= b_hit_new ? TagReady : b_tag_i;
      a_q    <= a_hit_new ? bc_data_i : a_data_i;
      b_q    <= b_hit_new ? bc_data_i : b_data_i;
    end else if (release_hit) begin
      busy_q <= 1'b0;
      sent_q <= 1'b0;
      at_q   <= TagReady;
      bt_q   <= TagReady;
    end else if (busy_q) begin
      if (disp_i) sent_q <= 1'b1;
      if (a_hit_old) begin
        at_q <= TagReady;
        a_q  <= bc_data_i;
      end
      if (b_hit_old) begin
        bt_q <= TagReady;
        b_q  <= bc_data_i;
      end
    end
  end

  assign busy_o  = busy_q;
  assign ready_o = busy_q && !sent_q && (at_q == TagReady) && (bt_q == TagReady);
  assign op_o    = op_q;
  assign a_o     = a_q;
  assign b_o     = b_q;
endmodule

// File: rtl/rs_array.sv
module rs_array
  import rs_pkg::*;
#(
  parameter int   DATA_W   = 16,
  parameter int   OP_W     = 3,
  parameter int   NUM_ENT  = 3,
  parameter tag_t BASE_TAG = tag_t'(10)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_valid_i,
  input  logic [OP_W-1:0]   issue_op_i,
  input  logic [3:0]        issue_a_tag_i,
  input  logic [DATA_W-1:0] issue_a_data_i,
  input  logic [3:0]        issue_b_tag_i,
  input  logic [DATA_W-1:0] issue_b_data_i,
  output logic              issue_stall_o,
  output logic [3:0]        issue_tag_o,
  input  logic              bcast_valid_i,
  input  logic [3:0]        bcast_tag_i,
  input  logic [DATA_W-1:0] bcast_data_i,
  output logic              disp_valid_o,
  output logic [OP_W-1:0]   disp_op_o,
  output logic [DATA_W-1:0] disp_a_o,
  output logic [DATA_W-1:0] disp_b_o,
  output logic [3:0]        disp_tag_o
);
  localparam int IdxW = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

  logic [NUM_ENT-1:0] ent_busy, ent_ready, alloc_gnt, alloc_vec, rd_gnt, disp_vec;
  logic [IdxW-1:0]    free_idx, rd_idx;
  logic               free_any, rd_any;
  logic [OP_W-1:0]    ent_op [NUM_ENT];
  logic [DATA_W-1:0]  ent_a  [NUM_ENT];
  logic [DATA_W-1:0]  ent_b  [NUM_ENT];
  logic               exec_q;
  tag_t               exec_tag_q;

  rs_pick #(.N(NUM_ENT)) i_free_pick (
    .req_i(~ent_busy), .gnt_o(alloc_gnt), .idx_o(free_idx), .any_o(free_any)
  );
  rs_pick #(.N(NUM_ENT)) i_ready_pick (
    .req_i(ent_ready), .gnt_o(rd_gnt), .idx_o(rd_idx), .any_o(rd_any)
  );

  assign issue_stall_o = !free_any;
  assign issue_tag_o   = BASE_TAG + tag_t'(free_idx);
  assign alloc_vec     = alloc_gnt & {NUM_ENT{issue_valid_i && free_any}};
  assign disp_valid_o  = rd_any && !exec_q;
  assign disp_vec      = rd_gnt & {NUM_ENT{disp_valid_o}};

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    rs_entry #(
      .DATA_W(DATA_W), .OP_W(OP_W), .MY_TAG(tag_t'(BASE_TAG + g))
    ) i_entry (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .alloc_i    (alloc_vec[g]),
      .op_i       (issue_op_i),
      .a_tag_i    (issue_a_tag_i),
      .a_data_i   (issue_a_data_i),
      .b_tag_i    (issue_b_tag_i),
      .b_data_i   (issue_b_data_i),
      .bc_valid_i (bcast_valid_i),
      .bc_tag_i   (bcast_tag_i),
      .bc_data_i  (bcast_data_i),
      .disp_i     (disp_vec[g]),
      .busy_o     (ent_busy[g]),
      .ready_o    (ent_ready[g]),
      .op_o       (ent_op[g]),
      .a_o        (ent_a[g]),
      .b_o        (ent_b[g])
    );
  end

  assign disp_op_o  = ent_op[rd_idx];
  assign disp_a_o   = ent_a[rd_idx];
  assign disp_b_o   = ent_b[rd_idx];
  assign disp_tag_o = BASE_TAG + tag_t'(rd_idx);

  // single operation in flight until its tag is broadcast
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exec_q     <= 1'b0;
      exec_tag_q <= TagReady;
    end else if (disp_valid_o) begin
      exec_q     <= 1'b1;
      exec_tag_q <= disp_tag_o;
    end else if (exec_q && bcast_valid_i && bcast_tag_i == exec_tag_q) begin
      exec_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rs_array_chk.sv
module rs_array_chk #(
  parameter int         NUM_ENT  = 3,
  parameter logic [3:0] BASE_TAG = 4'd10
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               issue_valid_i,
  input logic               issue_stall_o,
  input logic [3:0]         issue_tag_o,
  input logic               disp_valid_o,
  input logic [3:0]         disp_tag_o,
  input logic [NUM_ENT-1:0] ent_ready
);
  localparam logic [3:0] LastTag = BASE_TAG + 4'(NUM_ENT - 1);

  AST_ISSUE_TAG_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_stall_o |-> (issue_tag_o >= BASE_TAG && issue_tag_o <= LastTag)); // R1
  AST_STALL_AFTER_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(issue_stall_o) |-> $past(issue_valid_i)); // R5
  AST_DISP_ENTRY_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> ent_ready[disp_tag_o - BASE_TAG]); // R6
  AST_DISP_NOT_ISSUE_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && !issue_stall_o) |-> !(disp_valid_o && disp_tag_o == issue_tag_o)); // R7
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |=> !disp_valid_o); // R9
  AST_DISP_TAG_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> (disp_tag_o >= BASE_TAG && disp_tag_o <= LastTag)); // R6
endmodule

bind rs_array rs_array_chk #(.NUM_ENT(NUM_ENT), .BASE_TAG(BASE_TAG)) i_rs_array_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .issue_valid_i (issue_valid_i),
  .issue_stall_o (issue_stall_o),
  .issue_tag_o   (issue_tag_o),
  .disp_valid_o  (disp_valid_o),
  .disp_tag_o    (disp_tag_o),
  .ent_ready     (ent_ready)
);

// File: tb/test_rs_array.sv
module test_rs_array;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int OW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          iv = 1'b0;
  logic [OW-1:0] iop = '0;
  logic [3:0]    iat = '0, ibt = '0;
  logic [DW-1:0] iad = '0, ibd = '0;
  logic          bv = 1'b0;
  logic [3:0]    bt = '0;
  logic [DW-1:0] bd = '0;
  logic          stall, dv;
  logic [3:0]    itag, dtag;
  logic [OW-1:0] dop;
  logic [DW-1:0] da, db;
  int            nchk = 0, nerr = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rs_array #(.DATA_W(DW), .OP_W(OW)) i_rs_array (
    .clk_i(clk), .rst_ni(rst_n),
    .issue_valid_i(iv), .issue_op_i(iop),
    .issue_a_tag_i(iat), .issue_a_data_i(iad),
    .issue_b_tag_i(ibt), .issue_b_data_i(ibd),
    .issue_stall_o(stall), .issue_tag_o(itag),
    .bcast_valid_i(bv), .bcast_tag_i(bt), .bcast_data_i(bd),
    .disp_valid_o(dv), .disp_op_o(dop), .disp_a_o(da), .disp_b_o(db), .disp_tag_o(dtag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    iv = 1'b0;
    bv = 1'b0;
  endtask

  task automatic issue(input logic [OW-1:0] op, input logic [3:0] at, input logic [DW-1:0] ad,
                       input logic [3:0] btg, input logic [DW-1:0] bdat);
    iv = 1'b1; iop = op; iat = at; iad = ad; ibt = btg; ibd = bdat;
  endtask

  task automatic bcast(input logic [3:0] tg, input logic [DW-1:0] dat);
    bv = 1'b1; bt = tg; bd = dat;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    chk("R10 stall", 32'(stall), 0);
    chk("R10 disp", 32'(dv), 0);
    chk("R10 tag", 32'(itag), 10);

    // ready operands: dispatch one cycle after issue
    issue(1, 0, 16'h11, 0, 16'h22);
    chk("R7 no disp in issue cycle", 32'(dv), 0);
    chk("R1 issue tag", 32'(itag), 10);
    tick();
    chk("R6 disp valid", 32'(dv), 1);
    chk("R6 disp tag", 32'(dtag), 10);
    chk("R1 op", 32'(dop), 1);
    chk("R2 a", 32'(da), 16'h11);
    chk("R2 b", 32'(db), 16'h22);
    tick();
    chk("R9 busy unit", 32'(dv), 0);
    chk("R8 entry held", 32'(itag), 11);
    bcast(10, 16'h0);
    tick();
    chk("R8 entry freed", 32'(itag), 10);

    // fill all entries pending on tag 3
    for (int i = 0; i < 3; i++) begin
      issue(2, 3, 16'h0, 0, 16'(16'h100 + i));
      chk("R1 lowest free", 32'(itag), 32'(10 + i));
      tick();
    end
    chk("R5 stall full", 32'(stall), 1);
    issue(3, 0, 16'h5, 0, 16'h6);
    tick();
    chk("R5 issue ignored", 32'(dv), 0);
    bcast(7, 16'h77);
    tick();
    chk("R3 mismatch ignored", 32'(dv), 0);
    bcast(3, 16'h33);
    tick();
    chk("R6 lowest ready", 32'(dtag), 10);
    chk("R3 captured a", 32'(da), 16'h33);
    chk("R6 b of entry0", 32'(db), 16'h100);
    tick();
    chk("R9 one in flight", 32'(dv), 0);
    bcast(10, 16'h0);
    tick();
    chk("R6 next ready", 32'(dtag), 11);
    chk("R6 b of entry1", 32'(db), 16'h101);
    chk("R8 stall released", 32'(stall), 0);
    tick();
    bcast(11, 16'h0);
    tick();
    chk("R6 last ready", 32'(dtag), 12);
    chk("R6 b of entry2", 32'(db), 16'h102);
    tick();
    bcast(12, 16'h0);
    tick();
    chk("R8 all free disp", 32'(dv), 0);
    chk("R8 all free tag", 32'(itag), 10);

    // dependent chain: entry 11 waits on entry 10's result
    issue(4, 0, 16'h1, 0, 16'h2);
    tick();
    issue(5, 10, 16'h0, 0, 16'h3);
    chk("R1 chain tag", 32'(itag), 11);
    tick();
    chk("R9 busy after disp", 32'(dv), 0);
    bcast(10, 16'h55);
    tick();
    chk("R3 chain disp", 32'(dv), 1);
    chk("R3 chain tag", 32'(dtag), 11);
    chk("R3 chain a", 32'(da), 16'h55);
    chk("R3 chain op", 32'(dop), 5);
    tick();
    bcast(11, 16'h0);
    tick();

    // broadcast in the issue cycle
    issue(6, 9, 16'h0, 0, 16'h7);
    bcast(9, 16'h99);
    tick();
    chk("R4 same cycle disp", 32'(dv), 1);
    chk("R4 same cycle a", 32'(da), 16'h99);
    tick();
    bcast(10, 16'h0);
    tick();

    // sweep pending/ready combinations
    for (int k = 0; k < 4; k++) begin
      logic pa, pb;
      pa = k[0];
      pb = k[1];
      issue(7, pa ? 4'd4 : 4'd0, 16'h40, pb ? 4'd5 : 4'd0, 16'h50);
      tick();
      chk("R2 ready after issue", 32'(dv), 32'(!(pa || pb)));
      if (pa) begin
        bcast(4, 16'hA4);
        tick();
        chk("R7 ready after a", 32'(dv), 32'(!pb));
      end
      if (pb) begin
        bcast(5, 16'hB5);
        tick();
        chk("R7 ready after b", 32'(dv), 1);
      end
      chk("R2 sweep a", 32'(da), pa ? 32'hA4 : 32'h40);
      chk("R2 sweep b", 32'(db), pb ? 32'hB5 : 32'h50);
      tick();
      bcast(10, 16'h0);
      tick();
      chk("R8 sweep freed", 32'(itag), 10);
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule